// File: doc/BRIEF.md
# Glitch-free clock stop gate

This block sits between a free-running source clock and one bank of clock outputs. Normally every output in the bank copies the source clock. An asynchronous active-low stop request parks the whole bank low without cutting any high pulse short. When the request is withdrawn, the bank restarts so that its first high phase is a complete one.

Each clock bank gets its own instance, so stopping one bank leaves every other bank running. The stop input is resynchronized by two flops on the source clock's rising edge. The resulting enable is then re-registered on the falling edge, which means it can only change while the source clock is low. A stopped-status output reports when the bank is actually parked.

The level a floating stop pin takes, pulled high or pulled low, is decided at the pad. It is outside this block.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is low, and in the first cycles after reset is released with the stop input high, every output follows the source clock and the stopped flag is 0.
- R2: When the stop input goes low between two source rising edges, exactly two more source rising edges appear on the outputs. From the third rising edge on, the outputs stay low.
- R3: While stopped, every output is 0 for the whole source period, including the source high phase. No pulse is shortened.
- R4: When the stop input goes high between two source rising edges, the next two source rising edges are suppressed. The third one appears on the outputs and is followed by a complete high phase.
- R5: The stopped flag changes on a source rising edge. It is 1 during exactly those source periods in which the outputs are held low, and 0 in the periods in which the outputs pulse.
- R6: All WIDTH outputs carry the same value at all times.
- R7: A stop request that lasts for only one source rising edge removes exactly one output pulse, two periods later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces the gate into the running state |
| stop_n | input | 1 | Asynchronous active-low stop request |
| clk_out | output | WIDTH | Gated clock bank |
| stopped | output | 1 | 1 while the bank is parked low |

## Verification
The assertions assume that the stop input is held high during reset. They also assume that each level of the stop input is seen at no fewer than one source rising edge, so that the cycle counts in R2 and R4 are well defined. The stimulus meets both assumptions by changing the stop input only in the late low phase of the source clock, several nanoseconds before a rising edge. It applies long stops, long runs, a one-edge stop pulse, and a reset taken while the bank is parked.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int WIDTH = 4
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             stop_n,
  output logic [WIDTH-1:0] clk_out,
  output logic             stopped
);

  logic [1:0] sync_q;
  logic       run_q;
  logic       gated;

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], stop_n};

  always_ff @(negedge clk_src or negedge rst_n)
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= sync_q[1];

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) stopped <= 1'b0;
    else        stopped <= !run_q;

  assign gated   = clk_src & run_q;
  assign clk_out = {WIDTH{gated}};

endmodule

module clk_stop_gate_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_src,
  input logic             rst_n,
  input logic             stop_n,
  input logic [WIDTH-1:0] clk_out,
  input logic             stopped
);

  // R6
  a_r6_bank_uniform: assert property (@(negedge clk_src) disable iff (!rst_n)
    (clk_out == '0) || (clk_out == '1));

  // R3, R5
  a_r3_low_when_stopped: assert property (@(negedge clk_src) disable iff (!rst_n)
    stopped |-> (clk_out == '0));

  a_r5_pulse_when_running: assert property (@(negedge clk_src) disable iff (!rst_n)
    !stopped |-> (clk_out == '1));

  // R2
  a_r2_stop_latency: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!stop_n && !$past(stop_n) && !$past(stop_n, 2)) |=> stopped);

  // R4
  a_r4_restart_latency: assert property (@(posedge clk_src) disable iff (!rst_n)
    (stop_n && $past(stop_n) && $past(stop_n, 2)) |=> !stopped);

endmodule

bind clk_stop_gate clk_stop_gate_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_src(clk_src),
  .rst_n(rst_n),
  .stop_n(stop_n),
  .clk_out(clk_out),
  .stopped(stopped)
);

// File: tb/clk_stop_gate_bench.sv
module clk_stop_gate_bench;

  localparam int WIDTH = 4;

  logic             clk_src = 1'b0;
  logic             rst_n   = 1'b0;
  logic             stop_n  = 1'b1;
  logic [WIDTH-1:0] clk_out;
  logic             stopped;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  run      = 0;
  bit  p1 = 1, p2 = 1;
  bit  exp_q[$];

  always #10 clk_src = ~clk_src;

  clk_stop_gate #(.WIDTH(WIDTH)) u_clk_stop_gate (
    .clk_src(clk_src), .rst_n(rst_n), .stop_n(stop_n),
    .clk_out(clk_out), .stopped(stopped)
  );

  task automatic check(input string req, input logic [WIDTH:0] act, input logic [WIDTH:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive the stop level seen at the coming rising edge; the pulse at that edge
  // reflects the level from two edges earlier.
  task automatic drive(input bit v);
    @(negedge clk_src); #5;
    stop_n = v;
    exp_q.push_back(p2);
    p2 = p1;
    p1 = v;
    run = 1;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_src);
      if (run && exp_q.size() > 0) begin
        bit hi;
        hi = exp_q.pop_front();
        #5;
        check(hi ? "R2/R4 pulse passed" : "R3 output held low",
              {1'b0, clk_out}, {1'b0, {WIDTH{hi}}});
        #10;
        check("R5 stopped flag", {{WIDTH{1'b0}}, stopped}, {{WIDTH{1'b0}}, !hi});
        check("R6 low phase", {1'b0, clk_out}, '0);
      end
    end
  end

  task automatic do_reset();
    run = 0;
    @(negedge clk_src); #5;
    rst_n = 0;
    @(posedge clk_src); #5;
    check("R1 output runs in reset", {1'b0, clk_out}, {1'b0, {WIDTH{1'b1}}});
    check("R1 flag clear in reset", {{WIDTH{1'b0}}, stopped}, '0);
    exp_q.delete();
    p1 = 1; p2 = 1;
    @(negedge clk_src); #5;
    rst_n = 1;
  endtask

  initial begin : watchdog
    #2000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    do_reset();
    repeat (5) drive(1);      // R1
    repeat (8) drive(0);      // R2, R3
    repeat (8) drive(1);      // R4
    drive(0);                 // R7 single-edge stop
    repeat (6) drive(1);
    repeat (2) drive(0);
    drive(1);                 // R7 two-edge stop
    repeat (5) drive(1);
    repeat (4) drive(0);
    stop_n = 1;
    do_reset();               // R1 reset taken while parked
    repeat (4) drive(1);
    repeat (6) drive(0);
    repeat (6) drive(1);
    @(posedge clk_src); @(posedge clk_src); #20;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule